// File: doc/BRIEF.md
# Two-Tier Clock-Enable Prescaler

This block turns one base clock into two timing strobes for peripheral logic. Each strobe is high for one base-clock cycle. The fast strobe fires once every 2^n base cycles, where n comes from a 4-bit select field. The slow strobe counts fast strobes and fires once every 1, 2 or 4 of them, as chosen by a 2-bit select field. No derived clock is produced, so every consumer stays in the base clock domain and qualifies its logic with the strobe.

Each field has its own write strobe. A written value is held as a pending request. It is loaded into the active divider only when the divider reaches its terminal count, so no strobe interval is ever cut short. While a request is pending, a busy flag is high and the status output still shows the ratio code in force. Software polls these outputs to learn when the new ratio has taken hold. A second write before the first one is applied replaces the pending value.

Top module: `prescaler_two_tier`

## Requirements
- R1: After reset both status outputs read 0, both busy flags are low, and both strobes are high in every cycle (undivided base clock).
- R2: With fast code n in 0..9 the fast strobe fires once every 2^n base cycles. Codes 10..15 behave as 9, and the fast status then reads 9.
- R3: With slow code 0, 1 or 2 the slow strobe fires once every 1, 2 or 4 fast strobes. Code 3 behaves as 2, and the slow status then reads 2.
- R4: The slow strobe is never high in a cycle in which the fast strobe is low.
- R5: A write does not change the output right away. In the cycle after a write the matching busy flag is high, and the status still shows the code that was in force before.
- R6: A pending code is loaded only at the terminal count of its divider. The strobe interval that is running when the write lands completes at the old length.
- R7: After a write the fast busy flag clears within 512 base cycles and the slow busy flag clears within 2048 base cycles.
- R8: A write made while a change is still pending replaces the pending value. Busy stays high until the latest value is applied.
- R9: When the busy flag clears, the status equals the written code (after the capping described in R2 and R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_wr | input | 1 | Write strobe for the fast select field |
| hs_sel | input | 4 | Requested fast code (divide by 2^code) |
| ms_wr | input | 1 | Write strobe for the slow select field |
| ms_sel | input | 2 | Requested slow code (divide fast strobe by 2^code) |
| hs_tick | output | 1 | Fast enable strobe, one cycle wide |
| ms_tick | output | 1 | Slow enable strobe, one cycle wide |
| hs_status | output | 4 | Fast code currently in force |
| ms_status | output | 2 | Slow code currently in force |
| hs_busy | output | 1 | Fast change still pending |
| ms_busy | output | 1 | Slow change still pending |

## Verification
A write presented before a rising edge is captured on that edge. The busy flag therefore rises, and the status is seen unchanged, at the next falling edge, and the bench checks both there. The strobes are decoded from registered counter state, so the bench samples them at falling edges and counts whole cycles between consecutive strobes. It does this only after both busy flags have cleared, so that every measured interval belongs to the new ratio. Busy-clear latency is counted from the falling edge after the write, and the one directed interval test starts its count at a strobe and writes mid-interval, so the expected old-length interval falls on a known cycle.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;
    // Default field widths and code limits for the two-tier prescaler
    localparam int HS_SEL_W_DEF    = 4;
    localparam int MS_SEL_W_DEF    = 2;
    localparam int HS_MAX_CODE_DEF = 9;
    localparam int MS_MAX_CODE_DEF = 2;
endpackage

// File: rtl/prs_sel_pending.sv
// Holds a requested ratio code until the divider accepts it.
module prs_sel_pending #(
    parameter int SEL_W    = 4,
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [SEL_W-1:0]  data_i,
    input  logic              take_i,
    output logic [CODE_W-1:0] pend_code_o,
    output logic              valid_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              valid;
    } pend_t;

    pend_t pend_d, pend_q;
    logic [CODE_W-1:0] capped;

    always_comb begin
        capped = (data_i > SEL_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : CODE_W'(data_i);
        pend_d = pend_q;
        if (wr_i) begin
            pend_d.code  = capped;
            pend_d.valid = 1'b1;
        end else if (take_i) begin
            pend_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_code_o = pend_q.code;
    assign valid_o     = pend_q.valid;

    // R5: a write is always followed by a pending request
    assert_write_marks_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> valid_o);
endmodule

// File: rtl/prs_div_counter.sv
// Counts steps and emits a strobe at the terminal count of 2^act.
module prs_div_counter #(
    parameter int CODE_W   = 4,
    parameter int MAX_CODE = 9,
    parameter int CNT_W    = (MAX_CODE > 0) ? MAX_CODE : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              pend_valid_i,
    input  logic [CODE_W-1:0] pend_code_i,
    output logic              tick_o,
    output logic              take_o,
    output logic [CODE_W-1:0] act_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CODE_W-1:0] act;
    } div_t;

    div_t div_d, div_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] lim;
    logic             at_end;

    always_comb begin
        span   = (CNT_W+1)'(1) << div_q.act;
        lim    = CNT_W'(span - (CNT_W+1)'(1));
        at_end = (div_q.cnt == lim);
        tick_o = step_i && at_end;
        take_o = tick_o && pend_valid_i;
        div_d  = div_q;
        if (tick_o) begin
            div_d.cnt = '0;
            if (pend_valid_i) div_d.act = pend_code_i;
        end else if (step_i) begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign act_o = div_q.act;

    // R6: the active code moves only on the edge that closed an interval
    assert_apply_on_terminal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q.act != $past(div_q.act)) |-> $past(tick_o));

    // R2: the active code never exceeds its cap
    assert_act_capped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.act <= CODE_W'(MAX_CODE));
endmodule

// File: rtl/prs_ratio_tier.sv
// One divider tier: pending request plus counter.
module prs_ratio_tier #(
    parameter int SEL_W    = 4,
    parameter int MAX_CODE = 9,
    parameter int BOUND    = 512,
    localparam int CODE_W  = $clog2(MAX_CODE + 1),
    localparam int WAIT_W  = $clog2(BOUND + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              wr_i,
    input  logic [SEL_W-1:0]  data_i,
    output logic              tick_o,
    output logic [CODE_W-1:0] act_o,
    output logic              busy_o
);
    logic [CODE_W-1:0] pend_code;
    logic              take;

    prs_sel_pending #(.SEL_W(SEL_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_i),
        .data_i     (data_i),
        .take_i     (take),
        .pend_code_o(pend_code),
        .valid_o    (busy_o)
    );

    prs_div_counter #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step_i),
        .pend_valid_i(busy_o),
        .pend_code_i (pend_code),
        .tick_o      (tick_o),
        .take_o      (take),
        .act_o       (act_o)
    );

    // Checker: cycles spent busy since the latest write
    logic [WAIT_W-1:0] wait_q;
    always_ff @(posedge clk) begin
        if (!rst_n || wr_i || !busy_o) wait_q <= '0;
        else                           wait_q <= wait_q + 1'b1;
    end

    // R7: a pending change is applied within the bound of this tier
    assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (wait_q < WAIT_W'(BOUND)));
endmodule

// File: rtl/prescaler_two_tier.sv
module prescaler_two_tier #(
    parameter int HS_SEL_W    = prescaler_pkg::HS_SEL_W_DEF,
    parameter int MS_SEL_W    = prescaler_pkg::MS_SEL_W_DEF,
    parameter int HS_MAX_CODE = prescaler_pkg::HS_MAX_CODE_DEF,
    parameter int MS_MAX_CODE = prescaler_pkg::MS_MAX_CODE_DEF
) (
    input  logic                hs_wr,
    input  logic                clk,
    input  logic                rst_n,
    input  logic [HS_SEL_W-1:0] hs_sel,
    input  logic                ms_wr,
    input  logic [MS_SEL_W-1:0] ms_sel,
    output logic                hs_tick,
    output logic                ms_tick,
    output logic [HS_SEL_W-1:0] hs_status,
    output logic [MS_SEL_W-1:0] ms_status,
    output logic                hs_busy,
    output logic                ms_busy
);
    localparam int HS_CODE_W = $clog2(HS_MAX_CODE + 1);
    localparam int MS_CODE_W = $clog2(MS_MAX_CODE + 1);
    localparam int HS_BOUND  = 1 << HS_MAX_CODE;
    localparam int MS_BOUND  = (1 << MS_MAX_CODE) * HS_BOUND;

    logic [HS_CODE_W-1:0] hs_act;
    logic [MS_CODE_W-1:0] ms_act;

    prs_ratio_tier #(.SEL_W(HS_SEL_W), .MAX_CODE(HS_MAX_CODE), .BOUND(HS_BOUND)) u_fast (
        .clk   (clk),
        .rst_n (rst_n),
        .step_i(1'b1),
        .wr_i  (hs_wr),
        .data_i(hs_sel),
        .tick_o(hs_tick),
        .act_o (hs_act),
        .busy_o(hs_busy)
    );

    prs_ratio_tier #(.SEL_W(MS_SEL_W), .MAX_CODE(MS_MAX_CODE), .BOUND(MS_BOUND)) u_slow (
        .clk   (clk),
        .rst_n (rst_n),
        .step_i(hs_tick),
        .wr_i  (ms_wr),
        .data_i(ms_sel),
        .tick_o(ms_tick),
        .act_o (ms_act),
        .busy_o(ms_busy)
    );

    assign hs_status = HS_SEL_W'(hs_act);
    assign ms_status = MS_SEL_W'(ms_act);

    // R4: slow strobe nests inside the fast strobe
    assert_ms_only_with_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |-> hs_tick);

    // R3: slow status never reports a code above its cap
    assert_ms_status_capped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ms_status <= MS_SEL_W'(MS_MAX_CODE));
endmodule

// File: tb/prescaler_two_tier_test.sv
module prescaler_two_tier_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    // columns: fast code, slow code, fast status, slow status, fast period, slow period
    localparam int VEC [NVEC][6] = '{
        '{0, 0, 0, 0,   1,    1},
        '{1, 1, 1, 1,   2,    4},
        '{3, 2, 3, 2,   8,   32},
        '{2, 3, 2, 2,   4,   16},
        '{9, 0, 9, 0, 512,  512},
        '{12, 3, 9, 2, 512, 2048},
        '{5, 1, 5, 1,  32,   64},
        '{0, 2, 0, 2,   1,    4}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_wr = 1'b0;
    logic [3:0] hs_sel = '0;
    logic ms_wr = 1'b0;
    logic [1:0] ms_sel = '0;
    logic hs_tick, ms_tick, hs_busy, ms_busy;
    logic [3:0] hs_status;
    logic [1:0] ms_status;

    int n_chk = 0;
    int n_fail = 0;
    int r4_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prescaler_two_tier uut (
        .hs_wr(hs_wr), .clk(clk), .rst_n(rst_n), .hs_sel(hs_sel),
        .ms_wr(ms_wr), .ms_sel(ms_sel), .hs_tick(hs_tick), .ms_tick(ms_tick),
        .hs_status(hs_status), .ms_status(ms_status),
        .hs_busy(hs_busy), .ms_busy(ms_busy)
    );

    always @(negedge clk) if (rst_n && ms_tick && !hs_tick) r4_bad++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_le(input string req, input int act, input int lim);
        n_chk++;
        if (act > lim) begin
            n_fail++;
            $display("FAIL %s: got %0d expected at most %0d", req, act, lim);
        end
    endtask

    task automatic period(input bit slow, output int p);
        int g = 0;
        while (!(slow ? ms_tick : hs_tick) && g < 5000) begin @(negedge clk); g++; end
        p = 0;
        do begin @(negedge clk); p++; end while (!(slow ? ms_tick : hs_tick) && p < 5000);
    endtask

    task automatic wait_idle(output int hw, output int mw);
        int t = 0;
        hw = -1; mw = -1;
        while (t < 6000 && (hw < 0 || mw < 0)) begin
            if (!hs_busy && hw < 0) hw = t;
            if (!ms_busy && mw < 0) mw = t;
            @(negedge clk); t++;
        end
        if (hw < 0) hw = 99999;
        if (mw < 0) mw = 99999;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog (all): got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int prev_h = 0, prev_m = 0, hw, mw, p, n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 hs_status", hs_status, 0);
        chk("R1 ms_status", ms_status, 0);
        chk("R1 busy", {30'd0, hs_busy, ms_busy}, 0);
        chk("R1 hs_tick", hs_tick, 1);
        chk("R1 ms_tick", ms_tick, 1);
        period(1'b0, p); chk("R1 hs period", p, 1);
        period(1'b1, p); chk("R1 ms period", p, 1);

        for (int v = 0; v < NVEC; v++) begin
            hs_wr = 1'b1; hs_sel = 4'(VEC[v][0]);
            ms_wr = 1'b1; ms_sel = 2'(VEC[v][1]);
            @(negedge clk);
            hs_wr = 1'b0; ms_wr = 1'b0;
            // R5: busy set, status not yet moved
            chk("R5 hs_busy", hs_busy, 1);
            chk("R5 ms_busy", ms_busy, 1);
            chk("R5 hs_status held", hs_status, prev_h);
            chk("R5 ms_status held", ms_status, prev_m);
            wait_idle(hw, mw);
            chk_le("R7 hs wait", hw, 512);
            chk_le("R7 ms wait", mw, 2048);
            // R9 status after apply, capping per R2 / R3
            chk("R9 R2 hs_status", hs_status, VEC[v][2]);
            chk("R9 R3 ms_status", ms_status, VEC[v][3]);
            period(1'b0, p); chk("R2 hs period", p, VEC[v][4]);
            period(1'b1, p); chk("R3 ms period", p, VEC[v][5]);
            prev_h = VEC[v][2]; prev_m = VEC[v][3];
        end

        // R8: rewrite while pending replaces the request
        @(negedge clk); hs_wr = 1'b1; hs_sel = 4'd9;
        @(negedge clk); hs_wr = 1'b0;
        wait_idle(hw, mw);
        period(1'b0, p);
        @(negedge clk); @(negedge clk);
        hs_wr = 1'b1; hs_sel = 4'd3;
        @(negedge clk);
        chk("R8 busy after first write", hs_busy, 1);
        chk("R8 status still old", hs_status, 9);
        hs_sel = 4'd4;
        @(negedge clk); hs_wr = 1'b0;
        chk("R8 busy after rewrite", hs_busy, 1);
        wait_idle(hw, mw);
        chk("R8 latest value applied", hs_status, 4);
        period(1'b0, p); chk("R8 period of latest value", p, 16);

        // R6: interval running at the write keeps its old length
        n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 5) begin hs_wr = 1'b1; hs_sel = 4'd1; end
            if (n == 6) hs_wr = 1'b0;
        end while (!hs_tick && n < 5000);
        chk("R6 old interval completes", n, 16);
        period(1'b0, p); chk("R6 new interval", p, 2);
        chk("R6 status after apply", hs_status, 1);

        chk("R4 ms strobe outside hs strobe", r4_bad, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule